// File: doc/BRIEF.md
# Single-Wire Serial Identity Responder

This block is the device side of a single-wire, open-drain identification bus. It holds a fixed 64-bit identity, supplied as a parameter, and reports it to a bus master on request. The block never drives the line high. Its only output is an enable that pulls the shared wire to ground, and an external resistor supplies the high level. It watches the wire through a two-stage synchronizer. It times every action from the master's falling edges, using counters whose lengths come from a clock-frequency parameter, so it works at the bus's full rate of about 16 kbit/s.

A long low level is a bus reset, and the block answers it with a presence pulse. It then takes in an 8-bit command. Command 33h makes it stream its identity out. Command F0h starts the arbitration walk, in which several devices share the wire and the master separates them one bit at a time. Any other command makes the block stay quiet until the next reset.

Top module: `ow_id_slave`

## Requirements
- R1: After `rst`, and at any time the block is not sending a zero, `pull_o` is 0. The block never drives the line high.
- R2: When the line stays low for 120 µs (counted at the sampled input while the block is not pulling), any transaction in progress is abandoned and the block waits for the line to go high.
- R3: About 30 µs after the line returns high following a reset, the block pulls the line low for about 100 µs as a presence pulse. It pulls at no other time in that window.
- R4: The block samples each command bit 30 µs after the master's falling edge, where low means 0 and high means 1. Command bits arrive least significant bit first, so the byte sent as CCh is not taken as 33h.
- R5: After command 33h, the block sends the 64 identity bits in 64 master-started slots. For a 0 it pulls the line for about 30 µs from the falling edge. For a 1 it leaves the line released.
- R6: After command F0h, the block handles each identity bit in three slots: it sends the bit, then its complement, then reads the bit the master chose.
- R7: If the bit the master chose in the search differs from the block's own identity bit, the block stays silent until the next bus reset.
- R8: A command other than 33h or F0h leaves the block silent until the next bus reset.
- R9: Identity bit 0 is sent first. Bits 7:0 hold the family code, which is 01h in the default. Bits 55:8 hold the serial number and bits 63:56 hold the check byte.
- R10: After the 64th bit of a readout, or after a search that matches on all 64 bits, the block stays silent until the next bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency given by `CLK_HZ` |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Sampled level of the shared wire |
| pull_o | output | 1 | Pull-low enable for the open-drain driver |

## Verification
The bench drives the wire with four patterns. A full readout tells apart the 0 and 1 slot shapes and checks the byte order. A command byte that is the bit reversal of the readout code tells the least-significant-first rule apart from the opposite order. A full search with matching choices checks each bit and its complement. A search with a wrong choice at bit 10 checks that the block drops out at the right point. A reset issued partway through a readout shows that an abort returns the block to a state where it gives a clean presence pulse and accepts a new command. Throughout all of this, a model of the expected pull on every cycle shows that the block stays quiet on write slots and after it has finished.

// File: rtl/ow_id_slave.sv
module ow_id_slave #(
  parameter int          CLK_HZ   = 50_000_000,
  parameter logic [63:0] ID       = 64'hA7_0000_1234_5678_01,
  parameter int          RST_US   = 120,
  parameter int          PWAIT_US = 30,
  parameter int          PRES_US  = 100,
  parameter int          SLOT_US  = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic pull_o
);
  localparam int US      = CLK_HZ / 1_000_000;
  localparam int T_RST   = RST_US * US;
  localparam int T_PWAIT = PWAIT_US * US;
  localparam int T_PRES  = PRES_US * US;
  localparam int T_SLOT  = SLOT_US * US;
  localparam int CW      = $clog2(T_RST + T_PRES + T_PWAIT + 2);
  localparam logic [CW-1:0] C_RST   = CW'(T_RST - 1);
  localparam logic [CW-1:0] C_RSAT  = CW'(T_RST);
  localparam logic [CW-1:0] C_PWAIT = CW'(T_PWAIT - 1);
  localparam logic [CW-1:0] C_PRES  = CW'(T_PRES - 1);
  localparam logic [CW-1:0] C_SLOT  = CW'(T_SLOT - 1);

  typedef enum logic [2:0] {S_IDLE, S_RSTL, S_PWAIT, S_PRES, S_CMD, S_READ, S_SRCH} st_t;

  st_t           st;
  logic          s1, s2, s3, slot, pull_q;
  logic [CW-1:0] lowcnt, cnt;
  logic [5:0]    idx;
  logic [1:0]    phase;
  logic [7:0]    cmd;

  wire       fell     = s3 & ~s2;
  wire       cur_bit  = ID[idx];
  wire       send_val = (st == S_SRCH && phase == 2'd1) ? ~cur_bit : cur_bit;
  wire       sending  = (st == S_READ) || (st == S_SRCH && phase != 2'd2);
  wire       rst_hit  = !s2 && !pull_q && lowcnt == C_RST;
  wire [7:0] cmd_n    = {s2, cmd[7:1]};

  assign pull_o = pull_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
      st <= S_IDLE; slot <= 1'b0; pull_q <= 1'b0;
      lowcnt <= '0; cnt <= '0; idx <= '0; phase <= '0; cmd <= '0;
    end else begin
      s1 <= line_i; s2 <= s1; s3 <= s2;
      lowcnt <= (s2 || pull_q) ? '0 : (lowcnt == C_RSAT ? lowcnt : lowcnt + 1'b1);
      if (rst_hit) begin
        st <= S_RSTL; pull_q <= 1'b0; slot <= 1'b0;
      end else begin
        case (st)
          S_IDLE: ;
          S_RSTL: if (s2) begin st <= S_PWAIT; cnt <= '0; end
          S_PWAIT:
            if (cnt == C_PWAIT) begin st <= S_PRES; cnt <= '0; pull_q <= 1'b1; end
            else cnt <= cnt + 1'b1;
          S_PRES:
            if (cnt == C_PRES) begin
              st <= S_CMD; pull_q <= 1'b0; idx <= '0; slot <= 1'b0;
            end else cnt <= cnt + 1'b1;
          default:
            if (fell) begin
              slot <= 1'b1; cnt <= '0; pull_q <= sending && !send_val;
            end else if (slot) begin
              cnt <= cnt + 1'b1;
              if (cnt == C_SLOT) begin
                slot <= 1'b0; pull_q <= 1'b0;
                case (st)
                  S_CMD: begin
                    cmd <= cmd_n;
                    if (idx == 6'd7) begin
                      idx <= '0; phase <= '0;
                      st <= (cmd_n == 8'h33) ? S_READ : (cmd_n == 8'hF0) ? S_SRCH : S_IDLE;
                    end else idx <= idx + 1'b1;
                  end
                  S_READ:
                    if (idx == 6'd63) st <= S_IDLE;
                    else idx <= idx + 1'b1;
                  S_SRCH:
                    if (phase != 2'd2) phase <= phase + 1'b1;
                    else begin
                      phase <= '0;
                      if (s2 != cur_bit || idx == 6'd63) st <= S_IDLE;
                      else idx <= idx + 1'b1;
                    end
                  default: ;
                endcase
              end
            end
        endcase
      end
    end
  end

  a_r2_abort_on_long_low: assert property (@(posedge clk) disable iff (rst)
    rst_hit |=> (st == S_RSTL && !pull_q));
  a_r3_quiet_before_presence: assert property (@(posedge clk) disable iff (rst)
    st == S_PWAIT |-> !pull_q);
  a_r3_presence_driven: assert property (@(posedge clk) disable iff (rst)
    st == S_PRES |-> pull_q);
  a_r5_hold_bounded: assert property (@(posedge clk) disable iff (rst)
    (pull_q && (st == S_CMD || st == S_READ || st == S_SRCH)) |-> (slot && cnt <= C_SLOT));
  a_r6_phase_range: assert property (@(posedge clk) disable iff (rst)
    st == S_SRCH |-> phase != 2'd3);
  a_r8_idle_silent: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && $past(st == S_IDLE)) |-> !pull_q);
endmodule

// File: tb/sim_ow_id_slave.sv
`timescale 1ns/1ps
module sim_ow_id_slave;
  localparam logic [63:0] ID = 64'h5C_0000A1B2C3D4_01;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_low = 1'b0;
  logic pull;
  logic line;
  int   tests = 0, fails = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;
  assign line = ~(m_low | pull);

  ow_id_slave #(.CLK_HZ(1_000_000), .ID(ID)) u0 (
    .clk(clk), .rst(rst), .line_i(line), .pull_o(pull));

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic cyc(input logic ml, input int e, output logic seen);
    @(posedge clk); #1 m_low = ml;
    @(negedge clk);
    seen = line;
    if (e != 2) chk(pull === e[0], cur_req, "per-cycle pull", pull, e);
  endtask

  task automatic bus_reset();
    logic l, early, pres;
    early = 1'b0; pres = 1'b0;
    for (int o = 0; o < 480; o++) cyc(1'b1, (o < 40) ? 2 : 0, l);
    for (int o = 0; o < 300; o++) begin
      cyc(1'b0, (o >= 35 && o <= 130) ? 1 : ((o < 31 || o > 135) ? 0 : 2), l);
      if (o == 20) early = !l;
      if (o == 80) pres = !l;
    end
    chk(!early, "R3", "line quiet before presence", early, 0);
    chk(pres, "R3", "presence seen", pres, 1);
  endtask

  task automatic write_bit(input logic b);
    logic l;
    for (int o = 0; o < 70; o++) cyc(o < (b ? 6 : 60), 0, l);
  endtask

  task automatic write_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) write_bit(v[i]);
  endtask

  task automatic read_bit(input logic expb, output logic got);
    logic l;
    for (int o = 0; o < 70; o++) begin
      cyc(o < 2, expb ? 0 : ((o >= 5 && o <= 30) ? 1 : ((o < 2 || o > 35) ? 0 : 2)), l);
      if (o == 15) got = l;
    end
  endtask

  task automatic quiet_slots(input int n, input string req);
    logic g;
    for (int i = 0; i < n; i++) begin
      read_bit(1'b1, g);
      chk(g == 1'b1, req, "silent slot reads 1", g, 1);
    end
  endtask

  task automatic search(input int bad);
    logic a, c;
    cur_req = "R6";
    write_byte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      read_bit(ID[i], a);
      read_bit(!ID[i], c);
      chk(a == ID[i] && c == !ID[i], "R6", $sformatf("bit %0d pair", i), {a, c}, {ID[i], !ID[i]});
      write_bit(i == bad ? !ID[i] : ID[i]);
      if (i == bad) break;
    end
    if (bad >= 0) begin cur_req = "R7"; quiet_slots(6, "R7"); end
    else begin cur_req = "R10"; quiet_slots(4, "R10"); end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] got;
    logic g, l;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(pull == 1'b0, "R1", "pull after reset", pull, 0);
    for (int o = 0; o < 50; o++) cyc(1'b0, 0, l);

    cur_req = "R3"; bus_reset();
    cur_req = "R5"; write_byte(8'h33);
    for (int i = 0; i < 64; i++) begin read_bit(ID[i], g); got[i] = g; end
    for (int b = 0; b < 8; b++)
      chk(got[b*8 +: 8] == ID[b*8 +: 8], "R5", $sformatf("byte %0d", b), got[b*8 +: 8], ID[b*8 +: 8]);
    chk(got[7:0] == 8'h01, "R9", "family code first", got[7:0], 8'h01);
    chk(got == ID, "R9", "whole identity", got, ID);
    cur_req = "R10"; quiet_slots(8, "R10");

    cur_req = "R3"; bus_reset();
    cur_req = "R4"; write_byte(8'hCC);
    cur_req = "R8"; quiet_slots(16, "R8");

    cur_req = "R3"; bus_reset();
    search(-1);
    cur_req = "R3"; bus_reset();
    search(10);

    cur_req = "R3"; bus_reset();
    cur_req = "R5"; write_byte(8'h33);
    for (int i = 0; i < 20; i++) begin read_bit(ID[i], g); got[i] = g; end
    chk(got[19:0] == ID[19:0], "R5", "partial readout", got[19:0], ID[19:0]);
    cur_req = "R2"; bus_reset();
    cur_req = "R2"; write_byte(8'h33);
    for (int i = 0; i < 64; i++) begin read_bit(ID[i], g); got[i] = g; end
    chk(got == ID, "R2", "readout after abort", got, ID);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule